// File: doc/BRIEF.md
# Readout Buffer Throttle Controller

This block watches how full the event buffers of a readout concentrator are and tells the trigger system how hard it may push. Occupancy is compared against three programmable levels. The lowest level asks the trigger to slow down. The middle level stops new accepts, and any accept that still arrives is answered with an empty event fragment, so event numbering on every board stays aligned. The top level declares the board out of sync and asks for a buffer reset. The board then waits for a resync command.

Leaving the warning and stop states uses levels lowered by a programmable hysteresis, so the throttle does not chatter around a level. The board's own throttle state is combined with the throttle codes of several other boards into one output code, and the most severe code wins. An accept counter gives the running event number, and a resync command clears it.

Top module: `thr_ctrl`

## Requirements
- R1: After reset, the local state is ready. With all external inputs ready (0x8), `thr_out` is 0x8, `empty_evt` and `buf_reset` are 0, and `evt_id` is 0.
- R2: From ready, if `occ >= lvl_warn` and `occ < lvl_afull`, the local state becomes warning (code 0x1) on the next clock.
- R3: From ready or warning, if `occ >= lvl_afull` and `occ < lvl_full`, the local state becomes busy (code 0x4) on the next clock.
- R4: `empty_evt` is high in the same cycle as an `l1a` pulse, and only when the local state is busy.
- R5: From any state other than out-of-sync, `occ >= lvl_full` moves the local state to out-of-sync (code 0x2) on the next clock. `buf_reset` is high for exactly that one cycle.
- R6: Out-of-sync is held whatever the occupancy, until `resync` is seen.
- R7: Warning returns to ready when `occ < lvl_warn - hyst`. Busy returns to warning when `occ < lvl_afull - hyst`. Each exit level saturates at zero, and a zero exit level means the state is never left by occupancy.
- R8: `thr_out` is the most severe of the local code and every external code, ranked error (0xC) > out-of-sync (0x2) > busy (0x4) > warning (0x1) > ready (0x8).
- R9: Any code outside {0x8, 0x1, 0x4, 0x2, 0xC} on an external input is ranked as error, and `thr_out` becomes 0xC.
- R10: `evt_id` counts every `l1a` pulse, wrapping at its width. A `resync` sets it to 0 on the next clock, and this takes priority over a coinciding `l1a`.
- R11: `resync` returns the local state to ready on the next clock from any state, even when occupancy is at or above `lvl_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ | input | OCC_W | Current buffer occupancy |
| lvl_warn | input | OCC_W | Warning entry level |
| lvl_afull | input | OCC_W | Stop (busy) entry level |
| lvl_full | input | OCC_W | Out-of-sync entry level |
| hyst | input | OCC_W | Hysteresis subtracted for exit levels |
| l1a | input | 1 | Trigger accept pulse |
| resync | input | 1 | Resynchronisation command |
| ext_thr | input | 4*N_EXT | Throttle codes of other boards, 4 bits each |
| thr_out | output | 4 | Merged throttle code |
| empty_evt | output | 1 | Emit an empty fragment for this accept |
| buf_reset | output | 1 | One-cycle readout buffer reset request |
| evt_id | output | CNT_W | Running event number |

## Verification
The merge is swept over every pair of 4-bit external codes. A priority slip, such as ranking busy above out-of-sync or passing an illegal code through, would show up as a wrong output code. A long pseudo-random occupancy walk is run under several hysteresis settings, including one larger than the warning level. This catches a design that exits at the entry level, chatters, or wraps the exit level below zero. Directed steps target the other failure modes:
- a buffer reset that lasts more than one cycle;
- an out-of-sync state that falls back when occupancy drops;
- a resync that loses to a full buffer;
- empty fragments generated outside the busy state.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [3:0] {
        THR_READY = 4'h8,
        THR_WARN  = 4'h1,
        THR_BUSY  = 4'h4,
        THR_OOS   = 4'h2,
        THR_ERR   = 4'hC
    } thr_code_e;

    typedef enum logic [1:0] {
        ST_RDY,
        ST_WARN,
        ST_BUSY,
        ST_OOS
    } occ_state_e;

    // Severity rank; unknown codes rank as error.
    function automatic logic [2:0] thr_rank(input logic [3:0] c);
        case (c)
            4'h8:    return 3'd0;
            4'h1:    return 3'd1;
            4'h4:    return 3'd2;
            4'h2:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [3:0] rank_code(input logic [2:0] r);
        case (r)
            3'd0:    return THR_READY;
            3'd1:    return THR_WARN;
            3'd2:    return THR_BUSY;
            3'd3:    return THR_OOS;
            default: return THR_ERR;
        endcase
    endfunction

    function automatic logic [3:0] state_code(input occ_state_e s);
        case (s)
            ST_RDY:  return THR_READY;
            ST_WARN: return THR_WARN;
            ST_BUSY: return THR_BUSY;
            default: return THR_OOS;
        endcase
    endfunction

endpackage

// File: rtl/thr_occ_fsm.sv
module thr_occ_fsm
    import thr_pkg::*;
#(
    parameter int OCC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] lvl_warn,
    input  logic [OCC_W-1:0] lvl_afull,
    input  logic [OCC_W-1:0] lvl_full,
    input  logic [OCC_W-1:0] hyst,
    input  logic             l1a,
    input  logic             resync,
    output occ_state_e       state,
    output logic             empty_evt,
    output logic             buf_reset
);

    occ_state_e       nxt;
    logic [OCC_W-1:0] warn_exit;
    logic [OCC_W-1:0] afull_exit;

    // Exit levels saturate at zero
    assign warn_exit  = (lvl_warn  > hyst) ? lvl_warn  - hyst : '0;
    assign afull_exit = (lvl_afull > hyst) ? lvl_afull - hyst : '0;

    always_comb begin
        nxt = state;
        if (resync) begin
            nxt = ST_RDY;
        end else if (state != ST_OOS && occ >= lvl_full) begin
            nxt = ST_OOS;
        end else begin
            case (state)
                ST_RDY: begin
                    if (occ >= lvl_afull)     nxt = ST_BUSY;
                    else if (occ >= lvl_warn) nxt = ST_WARN;
                end
                ST_WARN: begin
                    if (occ >= lvl_afull)      nxt = ST_BUSY;
                    else if (occ < warn_exit)  nxt = ST_RDY;
                end
                ST_BUSY: begin
                    if (occ < afull_exit)      nxt = ST_WARN;
                end
                default: nxt = ST_OOS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RDY;
            buf_reset <= 1'b0;
        end else begin
            state     <= nxt;
            buf_reset <= (nxt == ST_OOS) && (state != ST_OOS);
        end
    end

    assign empty_evt = l1a && (state == ST_BUSY);

    p_empty_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
        empty_evt |-> (l1a && state == ST_BUSY));
    p_bufrst_single_r5: assert property (@(posedge clk) disable iff (rst)
        buf_reset |=> !buf_reset);
    p_bufrst_in_oos_r5: assert property (@(posedge clk) disable iff (rst)
        buf_reset |-> state == ST_OOS);
    p_oos_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OOS && !resync) |=> state == ST_OOS);
    p_resync_ready_r11: assert property (@(posedge clk) disable iff (rst)
        resync |=> state == ST_RDY);
    p_busy_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDY && !resync && occ >= lvl_afull && occ < lvl_full)
        |=> state == ST_BUSY);

endmodule

// File: rtl/thr_evt_cnt.sv
module thr_evt_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             l1a,
    input  logic             resync,
    output logic [CNT_W-1:0] evt_id
);

    always_ff @(posedge clk) begin
        if (rst || resync) evt_id <= '0;
        else if (l1a)      evt_id <= evt_id + 1'b1;
    end

    p_cnt_clear_r10: assert property (@(posedge clk) disable iff (rst)
        resync |=> evt_id == '0);
    p_cnt_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!resync && !l1a) |=> $stable(evt_id));

endmodule

// File: rtl/thr_merge.sv
module thr_merge
    import thr_pkg::*;
#(
    parameter int N_IN = 2
) (
    input  logic [4*N_IN-1:0] codes,
    output logic [3:0]        merged
);

    logic [2:0] rank [N_IN];

    for (genvar i = 0; i < N_IN; i++) begin : g_rank
        assign rank[i] = thr_rank(codes[4*i +: 4]);
    end

    always_comb begin
        logic [2:0] top;
        top = 3'd0;
        for (int i = 0; i < N_IN; i++) begin
            if (rank[i] > top) top = rank[i];
        end
        merged = rank_code(top);
    end

endmodule

// File: rtl/thr_ctrl.sv
module thr_ctrl
    import thr_pkg::*;
#(
    parameter int OCC_W = 8,
    parameter int N_EXT = 3,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OCC_W-1:0]   occ,
    input  logic [OCC_W-1:0]   lvl_warn,
    input  logic [OCC_W-1:0]   lvl_afull,
    input  logic [OCC_W-1:0]   lvl_full,
    input  logic [OCC_W-1:0]   hyst,
    input  logic               l1a,
    input  logic               resync,
    input  logic [4*N_EXT-1:0] ext_thr,
    output logic [3:0]         thr_out,
    output logic               empty_evt,
    output logic               buf_reset,
    output logic [CNT_W-1:0]   evt_id
);

    localparam int N_ALL = N_EXT + 1;

    occ_state_e       st;
    logic [3:0]       local_code;
    logic [4*N_ALL-1:0] all_codes;

    thr_occ_fsm #(.OCC_W(OCC_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .occ       (occ),
        .lvl_warn  (lvl_warn),
        .lvl_afull (lvl_afull),
        .lvl_full  (lvl_full),
        .hyst      (hyst),
        .l1a       (l1a),
        .resync    (resync),
        .state     (st),
        .empty_evt (empty_evt),
        .buf_reset (buf_reset)
    );

    thr_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .l1a    (l1a),
        .resync (resync),
        .evt_id (evt_id)
    );

    assign local_code = state_code(st);
    assign all_codes  = {ext_thr, local_code};

    thr_merge #(.N_IN(N_ALL)) u_merge (
        .codes  (all_codes),
        .merged (thr_out)
    );

    p_local_dominated_r8: assert property (@(posedge clk) disable iff (rst)
        thr_rank(thr_out) >= thr_rank(local_code));
    p_oos_visible_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OOS) |-> (thr_out == THR_OOS || thr_out == THR_ERR));

endmodule

// File: tb/thr_ctrl_test.sv
module thr_ctrl_test;

    localparam int OCC_W = 4;
    localparam int N_EXT = 2;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [OCC_W-1:0] occ = '0;
    logic [OCC_W-1:0] lvl_warn = 4'd5;
    logic [OCC_W-1:0] lvl_afull = 4'd9;
    logic [OCC_W-1:0] lvl_full = 4'd13;
    logic [OCC_W-1:0] hyst = 4'd2;
    logic             l1a = 1'b0;
    logic             resync = 1'b0;
    logic [4*N_EXT-1:0] ext_thr = 8'h88;
    logic [3:0]       thr_out;
    logic             empty_evt;
    logic             buf_reset;
    logic [CNT_W-1:0] evt_id;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    thr_ctrl #(.OCC_W(OCC_W), .N_EXT(N_EXT), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .occ(occ), .lvl_warn(lvl_warn),
        .lvl_afull(lvl_afull), .lvl_full(lvl_full), .hyst(hyst),
        .l1a(l1a), .resync(resync), .ext_thr(ext_thr),
        .thr_out(thr_out), .empty_evt(empty_evt),
        .buf_reset(buf_reset), .evt_id(evt_id)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sev(input int c);
        case (c)
            8: return 0; 1: return 1; 4: return 2; 2: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int sev_code(input int r);
        case (r)
            0: return 8; 1: return 1; 2: return 4; 3: return 2;
            default: return 12;
        endcase
    endfunction

    // Reference model state: 0 ready 1 warn 2 busy 3 oos
    int ms = 0;
    int mcnt = 0;

    function automatic int mstep(input int s, input int o, input int rs);
        int wx, ax;
        wx = (int'(lvl_warn) > int'(hyst)) ? int'(lvl_warn) - int'(hyst) : 0;
        ax = (int'(lvl_afull) > int'(hyst)) ? int'(lvl_afull) - int'(hyst) : 0;
        if (rs != 0) return 0;
        if (s != 3 && o >= int'(lvl_full)) return 3;
        case (s)
            0: if (o >= int'(lvl_afull)) return 2;
               else if (o >= int'(lvl_warn)) return 1;
               else return 0;
            1: if (o >= int'(lvl_afull)) return 2;
               else if (o < wx) return 0;
               else return 1;
            2: return (o < ax) ? 1 : 2;
            default: return 3;
        endcase
    endfunction

    // Drive one cycle at negedge, step model, check after posedge
    task automatic cyc(input int o, input bit a, input bit rs, input string req);
        int nx;
        @(negedge clk);
        occ = o[OCC_W-1:0]; l1a = a; resync = rs;
        #1;
        check("R4", int'(empty_evt), (a && ms == 2) ? 1 : 0);
        nx = mstep(ms, o, rs);
        @(posedge clk); #1;
        check("R5", int'(buf_reset), (nx == 3 && ms != 3) ? 1 : 0);
        mcnt = rs ? 0 : (a ? (mcnt + 1) % 256 : mcnt);
        ms = nx;
        check(req, int'(thr_out), sev_code(ms));
        check("R10", int'(evt_id), mcnt);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", int'(thr_out), 8);
        check("R1", int'(empty_evt), 0);
        check("R1", int'(buf_reset), 0);
        check("R1", int'(evt_id), 0);

        // R2 warning entry, R3 busy entry, R4 empty fragment
        cyc(5, 0, 0, "R2");
        cyc(9, 1, 0, "R3");
        cyc(9, 1, 0, "R4");
        cyc(8, 1, 0, "R7");       // 8 >= 7 stays busy
        cyc(6, 0, 0, "R7");       // 6 < 7 back to warning
        cyc(3, 1, 0, "R7");       // 3 = 5-2 not below, stay warning
        cyc(2, 0, 0, "R7");       // 2 < 3 ready
        // R5 full, R6 hold, R11 resync beats full
        cyc(13, 0, 0, "R5");
        cyc(0, 1, 0, "R6");
        cyc(0, 0, 0, "R6");
        cyc(15, 1, 1, "R11");
        cyc(0, 0, 0, "R1");

        // R7 sweep over hysteresis including saturation
        lf = 8'h5A;
        for (int h = 0; h < 4; h++) begin
            hyst = (h == 3) ? 4'd7 : h[OCC_W-1:0];
            for (int i = 0; i < 400; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                cyc(int'(lf[3:0]), lf[6], (ms == 3 && lf[5:4] == 2'b00), "R7");
            end
            cyc(0, 0, 1, "R11");
        end

        // R10 counter wrap
        for (int i = 0; i < 260; i++) cyc(0, 1, 0, "R10");
        cyc(0, 1, 1, "R10");

        // R8 and R9 merge sweep with local ready
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int r;
                @(negedge clk);
                ext_thr = {b[3:0], a[3:0]};
                #1;
                r = (sev(a) > sev(b)) ? sev(a) : sev(b);
                if (sev(a) == 4 || sev(b) == 4)
                    check("R9", int'(thr_out), 12);
                else
                    check("R8", int'(thr_out), sev_code(r));
            end
        end
        // R8 local out-of-sync beats external busy, loses to error
        @(negedge clk); ext_thr = 8'h84;
        cyc(14, 0, 0, "R8");
        @(negedge clk); ext_thr = 8'hC8; #1;
        check("R8", int'(thr_out), 12);
        ext_thr = 8'h88;
        cyc(0, 0, 1, "R11");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule